// File: doc/BRIEF.md
# Flash Program and Erase Controller

This block stands between a 32-bit register bus and a behavioural on-chip flash array. Programming and erasing are fenced off behind a two-word key sequence. Once unlocked, software can erase one whole page or program one half-word at a time. Status bits report when an operation is running, when it has ended, and when it was refused.

The array is modelled as a RAM of half-words. It comes out of reset fully erased, and an erased half-word reads 0xFFFF. Four registers are selected by `regSel`: 0 is the key register, 1 is control, 2 is status and 3 is the page address. The array has its own byte-addressed port. On that port, half-word writes start program operations, and reads return the half-word at the addressed location.

The length of each operation is a parameter given as a cycle count. Pages whose bit is set in the `PROTECT_MASK` parameter refuse both erase and program.

Top module: `flash_prog_ctrl`

## Requirements
- R1: After reset, control reads 0x80: bit 7 is the lock bit, bit 0 enables programming and bit 1 enables erase. Status reads 0, and every array location reads 0xFFFF.
- R2: Writing 0x45670123 to the key register and then 0xCDEF89AB on the next key write clears the lock, so control then reads 0.
- R3: If either key value is wrong, the block stays locked until reset, and a correct sequence written afterwards has no effect.
- R4: Control writes made while locked have no effect: control still reads 0x80, and no operation starts.
- R5: A control write with bit 7 set relocks the block and clears bits 0 and 1. No register write can clear bit 7; only a new key sequence does.
- R6: A control write with bits 1 and 6 set and bit 7 clear erases the page selected by address-register bits [PAGE_SHIFT +: PAGE_W]. Status bit 0 (busy) is high for exactly ERASE_CYCLES cycles, starting the cycle after the write. When busy falls, every half-word of that page reads 0xFFFF and the other pages are unchanged.
- R7: With control bit 0 set, a 16-bit write (`memHalf`=1) to an even address holding 0xFFFF raises busy for exactly PROG_CYCLES cycles. The location then reads the written data.
- R8: An array write has no effect (no busy, no flag, no array change) in any of these cases: it is a byte write, its address is odd, bit 0 is clear, the block is locked, busy is high, or it arrives in the same cycle as a control write.
- R9: A program or erase aimed at a protected page sets status bit 4 on the next cycle, never raises busy, and leaves the array unchanged.
- R10: Programming a half-word that does not read 0xFFFF sets status bit 2, never raises busy, and leaves the array unchanged.
- R11: Status bit 5 is set on the cycle busy falls. Writing 1 to status bit 2, 4 or 5 clears that bit, and writing 0 leaves it. If a bit is set and cleared in the same cycle, it stays set.
- R12: Control and address-register writes made while busy is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 2 | Register select: 0 key, 1 control, 2 status, 3 address |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for `regSel` |
| memWrEn | input | 1 | Array write strobe |
| memHalf | input | 1 | 1 = 16-bit access, 0 = byte access |
| memAddr | input | MEM_AW | Array byte address |
| memWrData | input | 16 | Array write data |
| memRdData | output | 16 | Half-word at `memAddr` |

## Verification
Two functions can fall in the same cycle. The first is an operation finishing, which sets the end-of-operation flag, while software writes 1 to clear that same flag. The bench provokes this by timing a status write so that it is sampled exactly on the edge where busy falls, and it judges the result by reading the flag as still set afterwards. The second is a control write landing in the same cycle as an array write. The bench drives both together and expects the array to stay unchanged and busy to stay low. A cycle-level reference model compares both read ports on every clock throughout.

// File: rtl/flash_prog_pkg.sv
package flash_prog_pkg;
  localparam logic [31:0] KEY_FIRST  = 32'h4567_0123;
  localparam logic [31:0] KEY_SECOND = 32'hCDEF_89AB;

  localparam logic [1:0] REG_KEY  = 2'd0;
  localparam logic [1:0] REG_CTRL = 2'd1;
  localparam logic [1:0] REG_STAT = 2'd2;
  localparam logic [1:0] REG_ADDR = 2'd3;

  localparam int CTRL_PROG  = 0;
  localparam int CTRL_ERASE = 1;
  localparam int CTRL_START = 6;
  localparam int CTRL_LOCK  = 7;

  localparam int STAT_BUSY    = 0;
  localparam int STAT_PROGERR = 2;
  localparam int STAT_WPERR   = 4;
  localparam int STAT_DONE    = 5;

  // strobes from control to datapath
  typedef struct packed {
    logic latchProg;
    logic commitProg;
    logic commitErase;
  } dpStrobe_t;
endpackage

// File: rtl/flash_prog_datapath.sv
module flash_prog_datapath
  import flash_prog_pkg::*;
#(
  parameter int NUM_PAGES  = 8,
  parameter int PAGE_BYTES = 32,
  localparam int HW_PER_PAGE = PAGE_BYTES / 2,
  localparam int ARRAY_HW    = NUM_PAGES * HW_PER_PAGE,
  localparam int PAGE_W      = $clog2(NUM_PAGES),
  localparam int HWP_W       = $clog2(HW_PER_PAGE),
  localparam int IDX_W       = PAGE_W + HWP_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [PAGE_W-1:0] erasePage,
  input  logic [IDX_W-1:0]  hwAddr,
  input  logic [15:0]       memWrData,
  output logic [15:0]       memRdData
);
  logic [15:0]      cells [ARRAY_HW];
  logic [IDX_W-1:0] pendIdx;
  logic [15:0]      pendData;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < ARRAY_HW; i++) cells[i] <= 16'hFFFF;
      pendIdx  <= '0;
      pendData <= '0;
    end else begin
      if (strobe.latchProg) begin
        pendIdx  <= hwAddr;
        pendData <= memWrData;
      end
      if (strobe.commitProg) cells[pendIdx] <= pendData;
      if (strobe.commitErase) begin
        for (int j = 0; j < HW_PER_PAGE; j++)
          cells[{erasePage, HWP_W'(j)}] <= 16'hFFFF;
      end
    end
  end

  assign memRdData = cells[hwAddr];
endmodule

// File: rtl/flash_prog_control.sv
module flash_prog_control
  import flash_prog_pkg::*;
#(
  parameter int NUM_PAGES    = 8,
  parameter int PAGE_BYTES   = 32,
  parameter int ERASE_CYCLES = 20,
  parameter int PROG_CYCLES  = 5,
  parameter logic [NUM_PAGES-1:0] PROTECT_MASK = '0,
  localparam int PAGE_SHIFT = $clog2(PAGE_BYTES),
  localparam int PAGE_W     = $clog2(NUM_PAGES),
  localparam int MEM_AW     = PAGE_SHIFT + PAGE_W,
  localparam int MAX_CYC    = (ERASE_CYCLES > PROG_CYCLES) ? ERASE_CYCLES : PROG_CYCLES,
  localparam int CNT_W      = $clog2(MAX_CYC + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [1:0]        regSel,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic              memWrEn,
  input  logic              memHalf,
  input  logic [MEM_AW-1:0] memAddr,
  input  logic [15:0]       curHalf,
  output dpStrobe_t         strobe,
  output logic [PAGE_W-1:0] erasePage
);
  logic locked, keyDead, keyHalf;
  logic progEn, eraseEn;
  logic busy, opIsErase;
  logic [CNT_W-1:0] cnt;
  logic progErr, wpErr, done;
  logic [31:0] addrReg;

  logic keyWr, ctrlSel, ctrlWr, statWr, addrWr;
  logic startErase, eraseProt, launchErase;
  logic progTry, progProt, launchProg, progErrSet, wpSet, finish;
  logic [PAGE_W-1:0] memPage;

  always_comb begin
    keyWr       = regWrEn && regSel == REG_KEY;
    ctrlSel     = regWrEn && regSel == REG_CTRL;
    ctrlWr      = ctrlSel && !locked && !busy;
    statWr      = regWrEn && regSel == REG_STAT;
    addrWr      = regWrEn && regSel == REG_ADDR && !busy;
    erasePage   = addrReg[PAGE_SHIFT +: PAGE_W];
    memPage     = memAddr[PAGE_SHIFT +: PAGE_W];
    startErase  = ctrlWr && !regWrData[CTRL_LOCK] && regWrData[CTRL_START] && regWrData[CTRL_ERASE];
    eraseProt   = PROTECT_MASK[erasePage];
    launchErase = startErase && !eraseProt;
    progTry     = memWrEn && memHalf && !memAddr[0] && progEn && !locked && !busy && !ctrlSel;
    progProt    = PROTECT_MASK[memPage];
    launchProg  = progTry && !progProt && curHalf == 16'hFFFF;
    progErrSet  = progTry && !progProt && curHalf != 16'hFFFF;
    wpSet       = (progTry && progProt) || (startErase && eraseProt);
    finish      = busy && cnt == '0;
  end

  assign strobe.latchProg   = launchProg;
  assign strobe.commitProg  = finish && !opIsErase;
  assign strobe.commitErase = finish && opIsErase;

  // key sequence and lock
  always_ff @(posedge clk) begin
    if (!rstN) begin
      locked  <= 1'b1;
      keyDead <= 1'b0;
      keyHalf <= 1'b0;
      progEn  <= 1'b0;
      eraseEn <= 1'b0;
      addrReg <= '0;
    end else begin
      if (keyWr && locked && !keyDead) begin
        if (!keyHalf) begin
          if (regWrData == KEY_FIRST) keyHalf <= 1'b1;
          else keyDead <= 1'b1;
        end else begin
          keyHalf <= 1'b0;
          if (regWrData == KEY_SECOND) locked <= 1'b0;
          else keyDead <= 1'b1;
        end
      end
      if (ctrlWr) begin
        if (regWrData[CTRL_LOCK]) begin
          locked  <= 1'b1;
          progEn  <= 1'b0;
          eraseEn <= 1'b0;
        end else begin
          progEn  <= regWrData[CTRL_PROG];
          eraseEn <= regWrData[CTRL_ERASE];
        end
      end
      if (addrWr) addrReg <= regWrData;
    end
  end

  // operation timing
  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy      <= 1'b0;
      opIsErase <= 1'b0;
      cnt       <= '0;
    end else if (launchErase) begin
      busy      <= 1'b1;
      opIsErase <= 1'b1;
      cnt       <= CNT_W'(ERASE_CYCLES - 1);
    end else if (launchProg) begin
      busy      <= 1'b1;
      opIsErase <= 1'b0;
      cnt       <= CNT_W'(PROG_CYCLES - 1);
    end else if (finish) begin
      busy <= 1'b0;
    end else if (busy) begin
      cnt <= cnt - 1'b1;
    end
  end

  // sticky flags, write-one-to-clear, set wins
  always_ff @(posedge clk) begin
    if (!rstN) begin
      progErr <= 1'b0;
      wpErr   <= 1'b0;
      done    <= 1'b0;
    end else begin
      progErr <= progErrSet || (progErr && !(statWr && regWrData[STAT_PROGERR]));
      wpErr   <= wpSet      || (wpErr   && !(statWr && regWrData[STAT_WPERR]));
      done    <= finish     || (done    && !(statWr && regWrData[STAT_DONE]));
    end
  end

  always_comb begin
    regRdData = '0;
    case (regSel)
      REG_CTRL: begin
        regRdData[CTRL_LOCK]  = locked;
        regRdData[CTRL_ERASE] = eraseEn;
        regRdData[CTRL_PROG]  = progEn;
      end
      REG_STAT: begin
        regRdData[STAT_BUSY]    = busy;
        regRdData[STAT_PROGERR] = progErr;
        regRdData[STAT_WPERR]   = wpErr;
        regRdData[STAT_DONE]    = done;
      end
      REG_ADDR: regRdData = addrReg;
      default:  regRdData = '0;
    endcase
  end
endmodule

// File: rtl/flash_prog_ctrl.sv
module flash_prog_ctrl
  import flash_prog_pkg::*;
#(
  parameter int NUM_PAGES    = 8,
  parameter int PAGE_BYTES   = 32,
  parameter int ERASE_CYCLES = 20,
  parameter int PROG_CYCLES  = 5,
  parameter logic [NUM_PAGES-1:0] PROTECT_MASK = 8'h80,
  localparam int PAGE_SHIFT = $clog2(PAGE_BYTES),
  localparam int PAGE_W     = $clog2(NUM_PAGES),
  localparam int MEM_AW     = PAGE_SHIFT + PAGE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [1:0]        regSel,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic              memWrEn,
  input  logic              memHalf,
  input  logic [MEM_AW-1:0] memAddr,
  input  logic [15:0]       memWrData,
  output logic [15:0]       memRdData
);
  dpStrobe_t         strobe;
  logic [PAGE_W-1:0] erasePage;

  flash_prog_control #(
    .NUM_PAGES(NUM_PAGES), .PAGE_BYTES(PAGE_BYTES),
    .ERASE_CYCLES(ERASE_CYCLES), .PROG_CYCLES(PROG_CYCLES),
    .PROTECT_MASK(PROTECT_MASK)
  ) u_control (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel),
    .regWrData(regWrData), .regRdData(regRdData), .memWrEn(memWrEn),
    .memHalf(memHalf), .memAddr(memAddr), .curHalf(memRdData),
    .strobe(strobe), .erasePage(erasePage)
  );

  flash_prog_datapath #(
    .NUM_PAGES(NUM_PAGES), .PAGE_BYTES(PAGE_BYTES)
  ) u_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .erasePage(erasePage),
    .hwAddr(memAddr[MEM_AW-1:1]), .memWrData(memWrData), .memRdData(memRdData)
  );
endmodule

// File: rtl/flash_prog_checks.sv
module flash_prog_checks
  import flash_prog_pkg::*;
#(
  parameter int PAGE_SHIFT = 5,
  parameter int PAGE_W     = 3,
  parameter int MEM_AW     = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [1:0]        regSel,
  input logic [31:0]       regRdData,
  input logic [MEM_AW-1:0] memAddr,
  input logic [15:0]       memRdData,
  input dpStrobe_t         strobe,
  input logic [PAGE_W-1:0] erasePage
);
  assert_single_strobe_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.latchProg, strobe.commitProg, strobe.commitErase}));

  assert_locked_no_prog_R4: assert property (@(posedge clk) disable iff (!rstN)
    (regSel == REG_CTRL && regRdData[CTRL_LOCK]) |-> !strobe.latchProg);

  assert_busy_no_launch_R8: assert property (@(posedge clk) disable iff (!rstN)
    (regSel == REG_STAT && regRdData[STAT_BUSY]) |-> !strobe.latchProg);

  assert_array_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.commitProg && !strobe.commitErase) |=> (!$stable(memAddr) || $stable(memRdData)));

  assert_erase_fills_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.commitErase && memAddr[PAGE_SHIFT +: PAGE_W] == erasePage)
      |=> (!$stable(memAddr) || memRdData == 16'hFFFF));

  assert_done_after_op_R11: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.commitProg || strobe.commitErase) |=> (regSel != REG_STAT || regRdData[STAT_DONE]));
endmodule

bind flash_prog_ctrl flash_prog_checks #(
  .PAGE_SHIFT(PAGE_SHIFT), .PAGE_W(PAGE_W), .MEM_AW(MEM_AW)
) u_checks (
  .clk(clk), .rstN(rstN), .regSel(regSel), .regRdData(regRdData),
  .memAddr(memAddr), .memRdData(memRdData), .strobe(strobe), .erasePage(erasePage)
);

// File: tb/flash_prog_ctrl_test.sv
module flash_prog_ctrl_test;
  localparam int CLK_PERIOD   = 10;
  localparam int NUM_PAGES    = 8;
  localparam int PAGE_BYTES   = 32;
  localparam int ERASE_CYCLES = 20;
  localparam int PROG_CYCLES  = 5;
  localparam logic [7:0] PROT = 8'h80;
  localparam int MEM_AW   = 8;
  localparam int HWPP     = PAGE_BYTES / 2;
  localparam int ARRAY_HW = NUM_PAGES * HWPP;

  logic clk = 1'b0, rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [1:0] regSel = 2'd0;
  logic [31:0] regWrData = '0, regRdData;
  logic memWrEn = 1'b0, memHalf = 1'b1;
  logic [MEM_AW-1:0] memAddr = '0;
  logic [15:0] memWrData = '0, memRdData;

  int checks = 0, failures = 0;
  string curReq = "R1";
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_prog_ctrl #(
    .NUM_PAGES(NUM_PAGES), .PAGE_BYTES(PAGE_BYTES), .ERASE_CYCLES(ERASE_CYCLES),
    .PROG_CYCLES(PROG_CYCLES), .PROTECT_MASK(PROT)
  ) uut (.*);

  // behavioural reference model
  int mLocked, mDead, mHalf, mProg, mErase, mBusy, mCnt, mOpErase, mPErr, mWErr, mDone;
  int mAddr, pendHw, pendData;
  int mArr [ARRAY_HW];
  bit ctrlW, statW, addrW, startE, progTry, finish, gP, prP;
  int ePage, pg, hw;

  always @(posedge clk) begin
    if (!rstN) begin
      mLocked = 1; mDead = 0; mHalf = 0; mProg = 0; mErase = 0; mBusy = 0; mCnt = 0;
      mOpErase = 0; mPErr = 0; mWErr = 0; mDone = 0; mAddr = 0; pendHw = 0; pendData = 0;
      for (int i = 0; i < ARRAY_HW; i++) mArr[i] = 16'hFFFF;
    end else begin
      ctrlW   = regWrEn && regSel == 1 && mLocked == 0 && mBusy == 0;
      statW   = regWrEn && regSel == 2;
      addrW   = regWrEn && regSel == 3 && mBusy == 0;
      ePage   = (mAddr / PAGE_BYTES) % NUM_PAGES;
      startE  = ctrlW && !regWrData[7] && regWrData[6] && regWrData[1];
      progTry = memWrEn && memHalf && !memAddr[0] && mProg != 0 && mLocked == 0 && mBusy == 0
                && !(regWrEn && regSel == 1);
      pg = int'(memAddr) / PAGE_BYTES;
      hw = int'(memAddr) / 2;
      finish = mBusy != 0 && mCnt == 0;
      prP = PROT[pg];
      gP = progTry && !prP && mArr[hw] == 16'hFFFF;
      if (statW && regWrData[2]) mPErr = 0;
      if (statW && regWrData[4]) mWErr = 0;
      if (statW && regWrData[5]) mDone = 0;
      if (progTry && !prP && mArr[hw] != 16'hFFFF) mPErr = 1;
      if ((progTry && prP) || (startE && PROT[ePage])) mWErr = 1;
      if (finish) begin
        mDone = 1; mBusy = 0;
        if (mOpErase != 0) for (int k = 0; k < HWPP; k++) mArr[ePage*HWPP + k] = 16'hFFFF;
        else mArr[pendHw] = pendData;
      end else if (mBusy != 0) mCnt--;
      if (startE && !PROT[ePage]) begin mBusy = 1; mCnt = ERASE_CYCLES - 1; mOpErase = 1; end
      if (gP) begin
        mBusy = 1; mCnt = PROG_CYCLES - 1; mOpErase = 0; pendHw = hw; pendData = int'(memWrData);
      end
      if (regWrEn && regSel == 0 && mLocked != 0 && mDead == 0) begin
        if (mHalf == 0) begin
          if (regWrData == 32'h4567_0123) mHalf = 1; else mDead = 1;
        end else begin
          mHalf = 0;
          if (regWrData == 32'hCDEF_89AB) mLocked = 0; else mDead = 1;
        end
      end
      if (ctrlW) begin
        if (regWrData[7]) begin mLocked = 1; mProg = 0; mErase = 0; end
        else begin mProg = regWrData[0]; mErase = regWrData[1]; end
      end
      if (addrW) mAddr = int'(regWrData);
    end
  end

  function automatic logic [31:0] modelRead(input logic [1:0] sel);
    logic [31:0] v = '0;
    case (sel)
      2'd1: begin v[7] = mLocked != 0; v[1] = mErase != 0; v[0] = mProg != 0; end
      2'd2: begin v[0] = mBusy != 0; v[2] = mPErr != 0; v[4] = mWErr != 0; v[5] = mDone != 0; end
      2'd3: v = mAddr;
      default: v = '0;
    endcase
    return v;
  endfunction

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rstN && !finished) begin
      checks++;
      if (regRdData !== modelRead(regSel) || memRdData !== 16'(mArr[memAddr/2])) begin
        failures++;
        $display("FAIL %s model compare: reg act=%h exp=%h mem act=%h exp=%h",
                 curReq, regRdData, modelRead(regSel), memRdData, 16'(mArr[memAddr/2]));
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] sel, input logic [31:0] data);
    @(posedge clk); #1;
    regWrEn = 1'b1; regSel = sel; regWrData = data;
    @(posedge clk); #1;
    regWrEn = 1'b0;
  endtask

  task automatic memWrite(input logic [MEM_AW-1:0] a, input logic [15:0] d, input logic half);
    @(posedge clk); #1;
    memWrEn = 1'b1; memAddr = a; memWrData = d; memHalf = half;
    @(posedge clk); #1;
    memWrEn = 1'b0; memHalf = 1'b1;
  endtask

  task automatic readReg(input logic [1:0] sel, output logic [31:0] v);
    regSel = sel; #1; v = regRdData;
  endtask

  task automatic readMem(input logic [MEM_AW-1:0] a, output logic [15:0] v);
    memAddr = a; #1; v = memRdData;
  endtask

  task automatic countBusy(output int n);
    logic [31:0] s;
    n = 0;
    for (int i = 0; i < 1000; i++) begin
      readReg(2'd2, s);
      if (!s[0]) break;
      n++;
      @(posedge clk); #1;
    end
  endtask

  task automatic unlock();
    regWrite(2'd0, 32'h4567_0123);
    regWrite(2'd0, 32'hCDEF_89AB);
  endtask

  task automatic doReset();
    @(posedge clk); #1; rstN = 1'b0;
    repeat (3) @(posedge clk);
    #1; rstN = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog: act=running exp=finished");
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] r;
    logic [15:0] m;
    int n;
    doReset();
    // R1 reset state
    curReq = "R1";
    readReg(2'd1, r); chk("R1 ctrl", r, 32'h80);
    readReg(2'd2, r); chk("R1 status", r, 32'h0);
    readMem(8'd100, m); chk("R1 array", m, 16'hFFFF);
    // R4 locked control write
    curReq = "R4";
    regWrite(2'd1, 32'h43);
    readReg(2'd1, r); chk("R4 ctrl", r, 32'h80);
    readReg(2'd2, r); chk("R4 status", r, 32'h0);
    // R8 array write while locked
    curReq = "R8";
    memWrite(8'd4, 16'h1234, 1'b1);
    readMem(8'd4, m); chk("R8 locked write", m, 16'hFFFF);
    // R2 unlock
    curReq = "R2";
    unlock();
    readReg(2'd1, r); chk("R2 unlocked", r, 32'h0);
    // R7 program
    curReq = "R7";
    regWrite(2'd1, 32'h1);
    memWrite(8'd4, 16'h1234, 1'b1);
    countBusy(n); chk("R7 busy length", n, PROG_CYCLES);
    readMem(8'd4, m); chk("R7 data", m, 16'h1234);
    // R11 done flag and write-one-to-clear
    curReq = "R11";
    readReg(2'd2, r); chk("R11 done set", r, 32'h20);
    regWrite(2'd2, 32'h0);
    readReg(2'd2, r); chk("R11 write0 keeps", r, 32'h20);
    regWrite(2'd2, 32'h20);
    readReg(2'd2, r); chk("R11 write1 clears", r, 32'h0);
    // R10 program non-erased
    curReq = "R10";
    memWrite(8'd4, 16'h0000, 1'b1);
    readReg(2'd2, r); chk("R10 prog error", r, 32'h04);
    readMem(8'd4, m); chk("R10 data kept", m, 16'h1234);
    regWrite(2'd2, 32'h04);
    // R8 byte and odd writes
    curReq = "R8";
    memWrite(8'd6, 16'h1111, 1'b0);
    readReg(2'd2, r); chk("R8 byte status", r, 32'h0);
    readMem(8'd6, m); chk("R8 byte data", m, 16'hFFFF);
    memWrite(8'd7, 16'h2222, 1'b1);
    readReg(2'd2, r); chk("R8 odd status", r, 32'h0);
    readMem(8'd6, m); chk("R8 odd data", m, 16'hFFFF);
    // R9 protected page
    curReq = "R9";
    memWrite(8'd224, 16'h5555, 1'b1);
    readReg(2'd2, r); chk("R9 prog wp", r, 32'h10);
    readMem(8'd224, m); chk("R9 prog data", m, 16'hFFFF);
    regWrite(2'd2, 32'h10);
    regWrite(2'd3, 32'hE0);
    regWrite(2'd1, 32'h42);
    readReg(2'd2, r); chk("R9 erase wp", r, 32'h10);
    regWrite(2'd2, 32'h10);
    regWrite(2'd1, 32'h1);
    // R11 set and clear in same cycle
    curReq = "R11";
    memWrite(8'd32, 16'hBEEF, 1'b1);
    countBusy(n);
    regWrite(2'd2, 32'h20);
    memWrite(8'd34, 16'h0101, 1'b1);
    repeat (PROG_CYCLES - 2) @(posedge clk);
    regWrite(2'd2, 32'h20);
    readReg(2'd2, r); chk("R11 set wins", r, 32'h20);
    // R8 write while busy, and together with control write
    curReq = "R8";
    memWrite(8'd36, 16'h7777, 1'b1);
    memWrite(8'd38, 16'h8888, 1'b1);
    countBusy(n);
    readMem(8'd38, m); chk("R8 busy write", m, 16'hFFFF);
    regWrite(2'd2, 32'h20);
    @(posedge clk); #1;
    regWrEn = 1'b1; regSel = 2'd1; regWrData = 32'h1;
    memWrEn = 1'b1; memAddr = 8'd40; memWrData = 16'h4242;
    @(posedge clk); #1;
    regWrEn = 1'b0; memWrEn = 1'b0;
    readReg(2'd2, r); chk("R8 same-cycle status", r, 32'h0);
    readMem(8'd40, m); chk("R8 same-cycle data", m, 16'hFFFF);
    // R6 page erase
    curReq = "R6";
    regWrite(2'd3, 32'h10);
    regWrite(2'd1, 32'h42);
    countBusy(n); chk("R6 busy length", n, ERASE_CYCLES);
    readMem(8'd4, m); chk("R6 erased", m, 16'hFFFF);
    readMem(8'd32, m); chk("R6 other page", m, 16'hBEEF);
    // R12 writes while busy
    curReq = "R12";
    regWrite(2'd1, 32'h42);
    regWrite(2'd3, 32'h55);
    regWrite(2'd1, 32'h80);
    countBusy(n);
    readReg(2'd3, r); chk("R12 addr kept", r, 32'h10);
    readReg(2'd1, r); chk("R12 ctrl kept", r, 32'h02);
    // R5 relock
    curReq = "R5";
    regWrite(2'd1, 32'h80);
    readReg(2'd1, r); chk("R5 relocked", r, 32'h80);
    regWrite(2'd1, 32'h0);
    readReg(2'd1, r); chk("R5 lock sticks", r, 32'h80);
    unlock();
    readReg(2'd1, r); chk("R5 unlock again", r, 32'h0);
    // R3 wrong key
    curReq = "R3";
    regWrite(2'd1, 32'h80);
    regWrite(2'd0, 32'h4567_0123);
    regWrite(2'd0, 32'h0000_0001);
    unlock();
    readReg(2'd1, r); chk("R3 second key wrong", r, 32'h80);
    doReset();
    regWrite(2'd0, 32'hDEAD_BEEF);
    unlock();
    readReg(2'd1, r); chk("R3 first key wrong", r, 32'h80);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule